// File: doc/BRIEF.md
# Dual-Half Address Generator

The block computes memory addresses for a signal-processing datapath. It has two identical halves. Each half keeps four register triplets, and each triplet holds a pointer, an offset and a modifier. Triplets 0 to 3 sit in the low half and triplets 4 to 7 in the high half.

In every cycle each half picks one of its own triplets and one update operation. It drives a registered 16-bit effective address and can write the modified pointer back. The low half and the high half work at the same time, so the unit gives two addresses per cycle.

The modifier register sets the arithmetic for its own pointer: plain wrap-around, circular buffer, or bit-reversed carry for FFT reordering. A 24-bit global bus can write any register and read any register back. The registers are 16 bits wide, so the bus zero-extends on reads and drops the upper byte on writes.

Top module: `agu_top`

## Requirements
- R1: A pointer is updated only with the offset and modifier of its own triplet. `lo_sel` chooses triplet 0..3 and `hi_sel` chooses triplet 4..7 (index 4 + `hi_sel`).
- R2: The effective address appears on `lo_ea`/`hi_ea` one clock after the operation is presented. For op codes 0 to 4, 6 and 7, it is the pointer value from before that clock edge.
- R3: Op codes are 0 none, 1 add one, 2 subtract one, 3 add offset, 4 subtract offset, 5 indexed, and 6/7 behave as none. Indexed drives the modified value (pointer plus offset) as the address and leaves the pointer unchanged. Codes 1 to 4 write the modified value back to the pointer.
- R4: A modifier of 0xFFFF, or any value from 0x8000 to 0xFFFE, selects linear arithmetic that wraps modulo 65536.
- R5: A modifier M from 0x0001 to 0x7FFF selects circular arithmetic with modulus M+1. The buffer base is the pointer with its low k bits cleared, where 2^k is the smallest power of two not below M+1. The step magnitude is at most M+1.
- R6: A modifier of 0x0000 selects reverse-carry arithmetic: the carry travels from the most significant bit toward bit 0.
- R7: `bus_rdata` bits [15:0] carry the register chosen by `bus_rkind` (0 pointer, 1 offset, 2 modifier, 3 reads zero) and `bus_ridx` (triplet 0..7). Bits [23:16] are always zero.
- R8: A bus write stores only `bus_wdata[15:0]` into the chosen register. Bits [23:16] are discarded.
- R9: When a bus write to a pointer lands in the same cycle as an update of that pointer, the bus value is the one that is kept.
- R10: After reset, every pointer and offset is 0x0000, every modifier is 0xFFFF, and both effective addresses are 0x0000.
- R11: Both halves can update their selected pointers in the same cycle, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lo_op | input | 3 | Update operation for the low half |
| lo_sel | input | 2 | Triplet chosen within the low half |
| hi_op | input | 3 | Update operation for the high half |
| hi_sel | input | 2 | Triplet chosen within the high half |
| bus_we | input | 1 | Bus write strobe |
| bus_wkind | input | 2 | Register kind to write: 0 pointer, 1 offset, 2 modifier |
| bus_widx | input | 3 | Triplet number to write |
| bus_wdata | input | 24 | Bus write data |
| bus_rkind | input | 2 | Register kind to read |
| bus_ridx | input | 3 | Triplet number to read |
| bus_rdata | output | 24 | Bus read data, zero-extended |
| lo_ea | output | 16 | Registered effective address of the low half |
| hi_ea | output | 16 | Registered effective address of the high half |

## Verification
The assertions observe pointer values only through the read port. The address and writeback properties therefore take effect only in cycles where the read selectors point at the pointer under update, and the directed tasks hold the selectors there during every update cycle. The properties do not check circular arithmetic, because its result is defined only when the pointer lies inside its buffer and the step does not exceed the modulus. Every circular-buffer case in the stimulus uses an in-buffer pointer and a step no larger than the modulus.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_INC1  = 3'd1,
      OP_DEC1  = 3'd2,
      OP_INCN  = 3'd3,
      OP_DECN  = 3'd4,
      OP_INDEX = 3'd5
   } agu_op_e;

   typedef enum logic [1:0] {
      KIND_PTR = 2'd0,
      KIND_OFS = 2'd1,
      KIND_MDF = 2'd2,
      KIND_NIL = 2'd3
   } agu_kind_e;

   typedef enum logic [1:0] {
      ARITH_LIN = 2'd0,
      ARITH_MOD = 2'd1,
      ARITH_REV = 2'd2
   } agu_arith_e;

endpackage

// File: rtl/agu_mode_dec.sv
module agu_mode_dec
   import agu_pkg::*;
#(
   parameter int AW     = 16,
   parameter bit REV_EN = 1'b1,
   parameter bit MOD_EN = 1'b1
) (
   input  logic [AW-1:0] mdf,
   output logic [1:0]    mode,
   output logic [AW-1:0] mask
);

   // smear the modifier downwards: yields 2^k-1 with 2^k >= mdf+1
   logic [AW-1:0] smear;
   assign smear[AW-1] = mdf[AW-1];
   for (genvar i = AW - 2; i >= 0; i--) begin : g_smear
      assign smear[i] = smear[i+1] | mdf[i];
   end
   assign mask = smear;

   always_comb begin
      mode = ARITH_LIN;
      if (&mdf) begin
         mode = ARITH_LIN;
      end else if (mdf == '0) begin
         mode = REV_EN ? ARITH_REV : ARITH_LIN;
      end else if (!mdf[AW-1]) begin
         mode = MOD_EN ? ARITH_MOD : ARITH_LIN;
      end
   end

endmodule

// File: rtl/agu_alu.sv
module agu_alu
   import agu_pkg::*;
#(
   parameter int AW     = 16,
   parameter bit REV_EN = 1'b1,
   parameter bit MOD_EN = 1'b1
) (
   input  logic [AW-1:0] ptr,
   input  logic [AW-1:0] ofs,
   input  logic [AW-1:0] mdf,
   input  logic [2:0]    op,
   output logic [AW-1:0] ea,
   output logic [AW-1:0] nxt,
   output logic          wb
);

   logic [AW-1:0] step;
   logic          sub;
   logic [1:0]    mode;
   logic [AW-1:0] mask;
   logic [AW-1:0] lin_res;
   logic [AW-1:0] rev_res;
   logic [AW-1:0] mod_res;
   logic [AW-1:0] res;

   agu_mode_dec #(.AW(AW), .REV_EN(REV_EN), .MOD_EN(MOD_EN)) u_dec (
      .mdf  (mdf),
      .mode (mode),
      .mask (mask)
   );

   always_comb begin
      step = '0;
      sub  = 1'b0;
      wb   = 1'b0;
      case (op)
         OP_INC1:  begin step = AW'(1); wb = 1'b1; end
         OP_DEC1:  begin step = AW'(1); sub = 1'b1; wb = 1'b1; end
         OP_INCN:  begin step = ofs; wb = 1'b1; end
         OP_DECN:  begin step = ofs; sub = 1'b1; wb = 1'b1; end
         OP_INDEX: begin step = ofs; end
         default:  begin step = '0; end
      endcase
   end

   assign lin_res = sub ? (ptr - step) : (ptr + step);

   if (REV_EN) begin : g_rev
      logic [AW-1:0] rp, rs, rsum;
      for (genvar i = 0; i < AW; i++) begin : g_bits
         assign rp[i]      = ptr[AW-1-i];
         assign rs[i]      = step[AW-1-i];
         assign rev_res[i] = rsum[AW-1-i];
      end
      assign rsum = sub ? (rp - rs) : (rp + rs);
   end else begin : g_norev
      assign rev_res = lin_res;
   end

   if (MOD_EN) begin : g_mod
      logic [AW:0] modv, off_w, stp_w, sum_w, up_w, dn_w;
      assign modv  = {1'b0, mdf} + {{AW{1'b0}}, 1'b1};
      assign off_w = {1'b0, ptr & mask};
      assign stp_w = {1'b0, step};
      assign sum_w = off_w + stp_w;
      assign up_w  = (sum_w >= modv) ? (sum_w - modv) : sum_w;
      assign dn_w  = (off_w >= stp_w) ? (off_w - stp_w) : (off_w + modv - stp_w);
      assign mod_res = (ptr & ~mask) | ((sub ? dn_w[AW-1:0] : up_w[AW-1:0]) & mask);
   end else begin : g_nomod
      logic [AW-1:0] mask_unused;
      assign mask_unused = mask;
      assign mod_res = lin_res;
   end

   always_comb begin
      case (mode)
         ARITH_MOD: res = mod_res;
         ARITH_REV: res = rev_res;
         default:   res = lin_res;
      endcase
   end

   assign nxt = res;
   assign ea  = (op == OP_INDEX) ? res : ptr;

endmodule

// File: rtl/agu_half.sv
module agu_half
   import agu_pkg::*;
#(
   parameter int AW     = 16,
   parameter int NTRIP  = 4,
   parameter bit REV_EN = 1'b1,
   parameter bit MOD_EN = 1'b1,
   localparam int SELW  = $clog2(NTRIP)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      op,
   input  logic [SELW-1:0] sel,
   input  logic            wr_en,
   input  logic [1:0]      wr_kind,
   input  logic [SELW-1:0] wr_slot,
   input  logic [AW-1:0]   wr_data,
   input  logic [1:0]      rd_kind,
   input  logic [SELW-1:0] rd_slot,
   output logic [AW-1:0]   rd_data,
   output logic [AW-1:0]   ea_q
);

   logic [AW-1:0] ptr_q [NTRIP];
   logic [AW-1:0] ofs_q [NTRIP];
   logic [AW-1:0] mdf_q [NTRIP];

   logic [AW-1:0] alu_ea;
   logic [AW-1:0] alu_nxt;
   logic          alu_wb;

   // the ALU only ever sees the selected triplet as a whole
   agu_alu #(.AW(AW), .REV_EN(REV_EN), .MOD_EN(MOD_EN)) u_alu (
      .ptr (ptr_q[sel]),
      .ofs (ofs_q[sel]),
      .mdf (mdf_q[sel]),
      .op  (op),
      .ea  (alu_ea),
      .nxt (alu_nxt),
      .wb  (alu_wb)
   );

   for (genvar g = 0; g < NTRIP; g++) begin : g_trip
      logic hit;
      assign hit = wr_en && (wr_slot == SELW'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ptr_q[g] <= '0;
         end else if (hit && (wr_kind == KIND_PTR)) begin
            ptr_q[g] <= wr_data;
         end else if (alu_wb && (sel == SELW'(g))) begin
            ptr_q[g] <= alu_nxt;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ofs_q[g] <= '0;
         end else if (hit && (wr_kind == KIND_OFS)) begin
            ofs_q[g] <= wr_data;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mdf_q[g] <= '1;
         end else if (hit && (wr_kind == KIND_MDF)) begin
            mdf_q[g] <= wr_data;
         end
      end
   end

   always_comb begin
      case (rd_kind)
         KIND_PTR: rd_data = ptr_q[rd_slot];
         KIND_OFS: rd_data = ofs_q[rd_slot];
         KIND_MDF: rd_data = mdf_q[rd_slot];
         default:  rd_data = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_q <= '0;
      end else begin
         ea_q <= alu_ea;
      end
   end

endmodule

// File: rtl/agu_top.sv
module agu_top
   import agu_pkg::*;
#(
   parameter int AW     = 16,
   parameter int BUSW   = 24,
   parameter int NTRIP  = 4,
   parameter bit REV_EN = 1'b1,
   parameter bit MOD_EN = 1'b1,
   localparam int SELW  = $clog2(NTRIP),
   localparam int IDXW  = SELW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [2:0]      lo_op,
   input  logic [SELW-1:0] lo_sel,
   input  logic [2:0]      hi_op,
   input  logic [SELW-1:0] hi_sel,
   input  logic            bus_we,
   input  logic [1:0]      bus_wkind,
   input  logic [IDXW-1:0] bus_widx,
   input  logic [BUSW-1:0] bus_wdata,
   input  logic [1:0]      bus_rkind,
   input  logic [IDXW-1:0] bus_ridx,
   output logic [BUSW-1:0] bus_rdata,
   output logic [AW-1:0]   lo_ea,
   output logic [AW-1:0]   hi_ea
);

   if (AW < 2) begin : g_bad_aw
      $error("agu_top: AW must be at least 2");
   end
   if (BUSW <= AW) begin : g_bad_busw
      $error("agu_top: BUSW must exceed AW");
   end
   if ((NTRIP < 2) || ((NTRIP & (NTRIP - 1)) != 0)) begin : g_bad_ntrip
      $error("agu_top: NTRIP must be a power of two, at least 2");
   end

   logic [2:0]      h_op  [2];
   logic [SELW-1:0] h_sel [2];
   logic [AW-1:0]   h_rd  [2];
   logic [AW-1:0]   h_ea  [2];
   logic [BUSW-AW-1:0] wdata_unused_bits;

   assign h_op[0]  = lo_op;
   assign h_op[1]  = hi_op;
   assign h_sel[0] = lo_sel;
   assign h_sel[1] = hi_sel;
   assign wdata_unused_bits = bus_wdata[BUSW-1:AW];

   for (genvar h = 0; h < 2; h++) begin : g_half
      agu_half #(.AW(AW), .NTRIP(NTRIP), .REV_EN(REV_EN), .MOD_EN(MOD_EN)) u_half (
         .clk     (clk),
         .rst_n   (rst_n),
         .op      (h_op[h]),
         .sel     (h_sel[h]),
         .wr_en   (bus_we && (bus_widx[SELW] == 1'(h))),
         .wr_kind (bus_wkind),
         .wr_slot (bus_widx[SELW-1:0]),
         .wr_data (bus_wdata[AW-1:0]),
         .rd_kind (bus_rkind),
         .rd_slot (bus_ridx[SELW-1:0]),
         .rd_data (h_rd[h]),
         .ea_q    (h_ea[h])
      );
   end

   assign bus_rdata = {{(BUSW-AW){1'b0}}, h_rd[bus_ridx[SELW]]};
   assign lo_ea     = h_ea[0];
   assign hi_ea     = h_ea[1];

endmodule

// File: rtl/agu_top_chk.sv
module agu_top_chk
   import agu_pkg::*;
#(
   parameter int AW    = 16,
   parameter int BUSW  = 24,
   parameter int NTRIP = 4,
   localparam int SELW = $clog2(NTRIP),
   localparam int IDXW = SELW + 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [2:0]      lo_op,
   input logic [SELW-1:0] lo_sel,
   input logic [2:0]      hi_op,
   input logic [SELW-1:0] hi_sel,
   input logic            bus_we,
   input logic [1:0]      bus_wkind,
   input logic [IDXW-1:0] bus_widx,
   input logic [BUSW-1:0] bus_wdata,
   input logic [1:0]      bus_rkind,
   input logic [IDXW-1:0] bus_ridx,
   input logic [BUSW-1:0] bus_rdata,
   input logic [AW-1:0]   lo_ea,
   input logic [AW-1:0]   hi_ea
);

   logic lo_watch, hi_watch;
   assign lo_watch = (bus_rkind == KIND_PTR) && (bus_ridx == {1'b0, lo_sel});
   assign hi_watch = (bus_rkind == KIND_PTR) && (bus_ridx == {1'b1, hi_sel});

   // R7: upper bus byte never carries data
   p_zero_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata >> AW) == '0);

   // R9: a pointer write is what reads back, even against a same-cycle update
   p_ptr_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_wkind == KIND_PTR) |=>
      ((bus_rkind == $past(bus_wkind) && bus_ridx == $past(bus_widx)) ->
       bus_rdata[AW-1:0] == $past(bus_wdata[AW-1:0])));

   // R8: offset and modifier keep the low bus bits only
   p_cfg_write_trunc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (bus_wkind == KIND_OFS || bus_wkind == KIND_MDF)) |=>
      ((bus_rkind == $past(bus_wkind) && bus_ridx == $past(bus_widx)) ->
       bus_rdata == {{(BUSW-AW){1'b0}}, $past(bus_wdata[AW-1:0])}));

   // R2: non-indexed ops present the pre-edge pointer one cycle later
   p_lo_ea_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_op != OP_INDEX && lo_watch) |=> lo_ea == $past(bus_rdata[AW-1:0]));

   p_hi_ea_pre_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_op != OP_INDEX && hi_watch) |=> hi_ea == $past(bus_rdata[AW-1:0]));

   // R3: indexed access leaves the pointer untouched
   p_lo_index_nowb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_op == OP_INDEX && lo_watch && !bus_we) |=>
      ((bus_rkind == $past(bus_rkind) && bus_ridx == $past(bus_ridx)) ->
       $stable(bus_rdata)));

   p_hi_index_nowb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_op == OP_INDEX && hi_watch && !bus_we) |=>
      ((bus_rkind == $past(bus_rkind) && bus_ridx == $past(bus_ridx)) ->
       $stable(bus_rdata)));

endmodule

bind agu_top agu_top_chk #(.AW(AW), .BUSW(BUSW), .NTRIP(NTRIP)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lo_op     (lo_op),
   .lo_sel    (lo_sel),
   .hi_op     (hi_op),
   .hi_sel    (hi_sel),
   .bus_we    (bus_we),
   .bus_wkind (bus_wkind),
   .bus_widx  (bus_widx),
   .bus_wdata (bus_wdata),
   .bus_rkind (bus_rkind),
   .bus_ridx  (bus_ridx),
   .bus_rdata (bus_rdata),
   .lo_ea     (lo_ea),
   .hi_ea     (hi_ea)
);

// File: tb/agu_top_bench.sv
`timescale 1ns/1ps
module agu_top_bench;

   localparam logic [1:0] K_PTR = 2'd0, K_OFS = 2'd1, K_MDF = 2'd2, K_NIL = 2'd3;
   localparam logic [2:0] C_NONE = 3'd0, C_INC1 = 3'd1, C_DEC1 = 3'd2,
                          C_INCN = 3'd3, C_DECN = 3'd4, C_IDX = 3'd5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  lo_op = '0, hi_op = '0;
   logic [1:0]  lo_sel = '0, hi_sel = '0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_wkind = '0;
   logic [2:0]  bus_widx = '0;
   logic [23:0] bus_wdata = '0;
   logic [1:0]  bus_rkind = '0;
   logic [2:0]  bus_ridx = '0;
   logic [23:0] bus_rdata;
   logic [15:0] lo_ea, hi_ea;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   agu_top u_agu_top (
      .clk(clk), .rst_n(rst_n),
      .lo_op(lo_op), .lo_sel(lo_sel), .hi_op(hi_op), .hi_sel(hi_sel),
      .bus_we(bus_we), .bus_wkind(bus_wkind), .bus_widx(bus_widx), .bus_wdata(bus_wdata),
      .bus_rkind(bus_rkind), .bus_ridx(bus_ridx), .bus_rdata(bus_rdata),
      .lo_ea(lo_ea), .hi_ea(hi_ea)
   );

   function automatic logic [15:0] flip(input logic [15:0] x);
      logic [15:0] y;
      for (int i = 0; i < 16; i++) y[i] = x[15-i];
      return y;
   endfunction

   // expected next pointer from the requirement text
   function automatic logic [15:0] expect_next(input logic [15:0] r, input logic [15:0] s,
                                               input logic dn, input logic [15:0] m);
      int modv, size, off, base;
      if (m[15]) return dn ? r - s : r + s;
      if (m == 16'h0000) return flip(dn ? flip(r) - flip(s) : flip(r) + flip(s));
      modv = int'(m) + 1;
      size = 1;
      while (size < modv) size = size * 2;
      off  = int'(r) % size;
      base = int'(r) - off;
      if (!dn) begin
         off = off + int'(s);
         if (off >= modv) off = off - modv;
      end else begin
         off = off - int'(s);
         if (off < 0) off = off + modv;
      end
      return 16'(base + off);
   endfunction

   task automatic chk(input string req, input string what, input logic [23:0] act,
                      input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      lo_op = C_NONE; hi_op = C_NONE; bus_we = 1'b0;
   endtask

   task automatic cyc();
      @(negedge clk);
      idle();
   endtask

   task automatic wr(input logic [1:0] k, input logic [2:0] idx, input logic [23:0] d);
      bus_we = 1'b1; bus_wkind = k; bus_widx = idx; bus_wdata = d;
      cyc();
   endtask

   task automatic rd(input logic [1:0] k, input logic [2:0] idx, output logic [23:0] d);
      bus_rkind = k; bus_ridx = idx;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic run_lo(input logic [2:0] op, input logic [1:0] sel);
      bus_rkind = K_PTR; bus_ridx = {1'b0, sel};
      lo_op = op; lo_sel = sel;
      cyc();
   endtask

   task automatic run_hi(input logic [2:0] op, input logic [1:0] sel);
      bus_rkind = K_PTR; bus_ridx = {1'b1, sel};
      hi_op = op; hi_sel = sel;
      cyc();
   endtask

   task automatic t_reset();
      logic [23:0] d;
      chk("R10", "lo_ea after reset", {8'h0, lo_ea}, 24'h0);
      chk("R10", "hi_ea after reset", {8'h0, hi_ea}, 24'h0);
      rd(K_PTR, 3'd0, d); chk("R10", "R0 reset", d, 24'h0);
      rd(K_OFS, 3'd3, d); chk("R10", "N3 reset", d, 24'h0);
      rd(K_MDF, 3'd5, d); chk("R10", "M5 reset", d, 24'h00FFFF);
   endtask

   task automatic t_bus_width();
      logic [23:0] d;
      wr(K_PTR, 3'd2, 24'hAB1234);
      rd(K_PTR, 3'd2, d); chk("R8", "R2 upper byte dropped", d, 24'h001234);
      wr(K_OFS, 3'd6, 24'hFF00FF);
      rd(K_OFS, 3'd6, d); chk("R7", "N6 zero-extended", d, 24'h0000FF);
      rd(K_NIL, 3'd6, d); chk("R7", "kind 3 reads zero", d, 24'h0);
   endtask

   task automatic t_linear();
      logic [23:0] d;
      wr(K_PTR, 3'd0, 24'h00FFFE);
      run_lo(C_INC1, 2'd0);
      chk("R2", "post-inc ea is old pointer", {8'h0, lo_ea}, 24'h00FFFE);
      rd(K_PTR, 3'd0, d); chk("R4", "R0 +1", d, 24'h00FFFF);
      run_lo(C_INC1, 2'd0);
      rd(K_PTR, 3'd0, d); chk("R4", "R0 wraps to 0", d, 24'h0);
      wr(K_OFS, 3'd0, 24'h000005);
      run_lo(C_DECN, 2'd0);
      rd(K_PTR, 3'd0, d); chk("R4", "R0 -N0 wraps", d, 24'h00FFFB);
      wr(K_MDF, 3'd0, 24'h008000);
      run_lo(C_INC1, 2'd0);
      rd(K_PTR, 3'd0, d); chk("R4", "reserved modifier is linear", d, 24'h00FFFC);
   endtask

   task automatic t_modulo();
      logic [23:0] d;
      logic [15:0] e;
      wr(K_MDF, 3'd1, 24'h000009);
      wr(K_PTR, 3'd1, 24'h000027);
      wr(K_OFS, 3'd1, 24'h000004);
      run_lo(C_INCN, 2'd1);
      e = expect_next(16'h0027, 16'h4, 1'b0, 16'h9);
      rd(K_PTR, 3'd1, d); chk("R5", "modulo +N wraps to base+1", d, {8'h0, e});
      chk("R5", "modulo model value", {8'h0, e}, 24'h000021);
      run_lo(C_DEC1, 2'd1);
      rd(K_PTR, 3'd1, d); chk("R5", "modulo -1 to base", d, 24'h000020);
      run_lo(C_DEC1, 2'd1);
      rd(K_PTR, 3'd1, d); chk("R5", "modulo -1 below base wraps to top", d, 24'h000029);
      run_lo(C_DECN, 2'd1);
      rd(K_PTR, 3'd1, d);
      chk("R5", "modulo -N", d, {8'h0, expect_next(16'h0029, 16'h4, 1'b1, 16'h9)});
   endtask

   task automatic t_reverse();
      logic [23:0] d;
      logic [15:0] seq [4];
      seq[0] = 16'h0008; seq[1] = 16'h0004; seq[2] = 16'h000C; seq[3] = 16'h0002;
      wr(K_MDF, 3'd4, 24'h0);
      wr(K_PTR, 3'd4, 24'h0);
      wr(K_OFS, 3'd4, 24'h000008);
      for (int i = 0; i < 4; i++) begin
         run_hi(C_INCN, 2'd0);
         rd(K_PTR, 3'd4, d);
         chk("R6", "reverse-carry +N sequence", d, {8'h0, seq[i]});
      end
      run_hi(C_DEC1, 2'd0);
      rd(K_PTR, 3'd4, d);
      chk("R6", "reverse-carry -1", d, {8'h0, expect_next(16'h0002, 16'h1, 1'b1, 16'h0)});
   endtask

   task automatic t_index();
      logic [23:0] d;
      wr(K_PTR, 3'd3, 24'h000100);
      wr(K_OFS, 3'd3, 24'h000020);
      run_lo(C_IDX, 2'd3);
      chk("R3", "indexed ea is R3+N3", {8'h0, lo_ea}, 24'h000120);
      rd(K_PTR, 3'd3, d); chk("R3", "indexed keeps R3", d, 24'h000100);
      run_lo(3'd7, 2'd3);
      chk("R3", "op 7 ea is R3", {8'h0, lo_ea}, 24'h000100);
      rd(K_PTR, 3'd3, d); chk("R3", "op 7 keeps R3", d, 24'h000100);
   endtask

   task automatic t_binding_parallel();
      logic [23:0] d;
      wr(K_OFS, 3'd0, 24'h000001);
      wr(K_PTR, 3'd2, 24'h000010);
      wr(K_OFS, 3'd2, 24'h000040);
      wr(K_MDF, 3'd2, 24'h00FFFF);
      wr(K_PTR, 3'd7, 24'h000500);
      wr(K_OFS, 3'd7, 24'h000003);
      lo_op = C_INCN; lo_sel = 2'd2;
      hi_op = C_DECN; hi_sel = 2'd3;
      cyc();
      chk("R11", "lo_ea in parallel cycle", {8'h0, lo_ea}, 24'h000010);
      chk("R11", "hi_ea in parallel cycle", {8'h0, hi_ea}, 24'h000500);
      rd(K_PTR, 3'd2, d); chk("R1", "R2 stepped by N2 only", d, 24'h000050);
      rd(K_PTR, 3'd7, d); chk("R1", "R7 stepped by N7 only", d, 24'h0004FD);
   endtask

   task automatic t_priority();
      logic [23:0] d;
      wr(K_PTR, 3'd5, 24'h000030);
      bus_rkind = K_PTR; bus_ridx = 3'd5;
      hi_op = C_INC1; hi_sel = 2'd1;
      bus_we = 1'b1; bus_wkind = K_PTR; bus_widx = 3'd5; bus_wdata = 24'h120777;
      cyc();
      chk("R9", "hi_ea shows old R5", {8'h0, hi_ea}, 24'h000030);
      rd(K_PTR, 3'd5, d); chk("R9", "bus write beats update", d, 24'h000777);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired before the tests completed");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bus_width();
      t_linear();
      t_modulo();
      t_reverse();
      t_index();
      t_binding_parallel();
      t_priority();
      finish_run();
   end

endmodule